// File: doc/BRIEF.md
# Two-Wire Avionics Serial Word Receiver

This block turns a return-to-zero serial stream, carried on a pair of wires (one wire pulses for a one bit, the other for a zero bit, both low between bits), into 32-bit words for a host. It runs on a single clock at four times the bit rate. The clock is oversampled, a bit is taken from the middle of each pulse, the word is framed by the idle gaps between words, and the host gets the result either one byte at a time as each group of eight bits lands or as a whole 32-bit word once the last bit is in.

The host sets the receiver up through a few control inputs: enable, delivery width, parity checking, and a strobe that hides the next word from the ready output. It reads data through a data-acknowledge strobe and clears errors through a status-read strobe. An external label filter answers on a match input when the first byte is complete. A word it rejects leaves no trace at all. Any error stops reception until the host clears it, and the receiver then waits for an idle gap before it accepts the next word.

Top module: `a429_word_rx`

## Requirements
- R1: A bit is a one when `line_one` is high and `line_zero` is low, and a zero when the reverse holds. The first bit of a word lands in bit 0 of `data_word`. Byte k of the word (k = 0..3) is bits 8k+7..8k, and in byte mode it is presented on `data_byte` with the earlier bit in the LSB.
- R2: After reset, after `ctl_enable` rises, or after an error, a word is accepted only once both lines have been low for at least 12 consecutive clocks. Bits that arrive before that gap are ignored and raise no flag.
- R3: In word mode (`ctl_wide`=1), `rx_ready` and `first_char` rise together on the third rising clock edge after the clock edge that first samples the 32nd bit high, and `data_word` holds the word at that point.
- R4: In byte mode (`ctl_wide`=0), `rx_ready` rises and `data_byte` updates after each group of 8 bits. `first_char` rises only with the first byte of a word.
- R5: With `ctl_parity_en`=1, a 32-bit word whose count of ones is even sets `err_parity` and leaves `rx_ready` low for that word (byte mode: for the fourth byte). With `ctl_parity_en`=0, bit 31 is plain data.
- R6: Both lines high at the same time during an armed word sets `err_seq`.
- R7: Between 1 and 31 bits followed by a 12-clock null gap sets `err_seq`.
- R8: A 33rd bit before the gap sets `err_seq`. The 32-bit word that was already completed stays delivered.
- R9: A completed word (or byte) that arrives while `rx_ready` is still high sets `err_overwrite`, replaces the data and keeps `rx_ready` high.
- R10: A pulse on `ctl_skip_wr` keeps `rx_ready` low for the next word only. `first_char` and the data still update, and the suppression clears itself when that word ends.
- R11: While `err_any` is high no word is accepted. A `stat_rd` pulse clears all three error flags.
- R12: If `lbl_ok` is low on the clock where the first byte completes, the word raises neither `rx_ready`, `first_char` nor any error.
- R13: With `ctl_enable` low the line inputs are ignored.
- R14: A `data_rd` pulse clears `rx_ready` and `first_char`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at four times the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| line_one | input | 1 | Line that pulses high for a one bit |
| line_zero | input | 1 | Line that pulses high for a zero bit |
| ctl_enable | input | 1 | Receiver enable |
| ctl_wide | input | 1 | 1: whole-word delivery, 0: byte-at-a-time delivery |
| ctl_parity_en | input | 1 | Odd parity check on the 32nd bit |
| ctl_skip_wr | input | 1 | Pulse: hide the ready output for the next word |
| lbl_ok | input | 1 | Label filter match, sampled as the first byte completes |
| stat_rd | input | 1 | Status read strobe; clears error flags |
| data_rd | input | 1 | Data read strobe; clears ready and first-character |
| rx_ready | output | 1 | Data available |
| first_char | output | 1 | First byte (byte mode) or valid word (word mode) |
| data_byte | output | 8 | Most recently delivered byte |
| data_word | output | 32 | Most recently delivered word (word mode) |
| err_parity | output | 1 | Parity error flag |
| err_overwrite | output | 1 | Unread data replaced |
| err_seq | output | 1 | Framing/sequence error flag |
| err_any | output | 1 | OR of the three error flags |

## Verification
The hardest states to reach are the framing faults that only show up around the edges of a word. One is a 33rd pulse that follows a word already delivered. Another is a word that arrives just after reset or after an error is cleared, before any idle gap has been seen. The bench reaches them by building words bit by bit from a task that owns the four-clock cell. It can stop after any count, add an extra bit, drive both wires high, or start a word with no gap in front of it. A hand-timed last bit pins the exact three-clock latency of the ready output.

// File: rtl/a429_rx_pkg.sv
package a429_rx_pkg;
  // state of the line pair, packed as {line_one, line_zero}
  typedef enum logic [1:0] {
    LN_NULL = 2'b00,
    LN_ZERO = 2'b01,
    LN_ONE  = 2'b10,
    LN_BAD  = 2'b11
  } line_t;
endpackage

// File: rtl/a429_rx_sampler.sv
module a429_rx_sampler
  import a429_rx_pkg::*;
#(
  parameter int OVS       = 4,
  parameter int GAP_CELLS = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic line_one,
  input  logic line_zero,
  output logic bit_stb,
  output logic bit_val,
  output logic both_hi,
  output logic gap_lvl
);
  localparam int GAP_CLKS = OVS * GAP_CELLS;
  localparam int NC_W     = $clog2(GAP_CLKS + 1);

  line_t           s1, s2;
  logic            pend;
  logic [NC_W-1:0] ncnt;
  logic            s1_single;

  assign s1_single = (s1 == LN_ONE) || (s1 == LN_ZERO);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      s1   <= LN_NULL;
      s2   <= LN_NULL;
      pend <= 1'b0;
      ncnt <= '0;
    end else begin
      s1   <= line_t'({line_one, line_zero});
      s2   <= s1;
      // rising edge of either line: take the next sample as cell centre
      pend <= s1_single && (s2 == LN_NULL);
      if (s1 == LN_NULL) begin
        if (ncnt != NC_W'(GAP_CLKS)) ncnt <= ncnt + 1'b1;
      end else begin
        ncnt <= '0;
      end
    end
  end

  assign bit_stb = pend && s1_single;
  assign bit_val = (s1 == LN_ONE);
  assign both_hi = (s1 == LN_BAD);
  assign gap_lvl = (ncnt == NC_W'(GAP_CLKS));
endmodule

// File: rtl/a429_rx_framer.sv
module a429_rx_framer #(
  parameter int WORD_BITS = 32,
  parameter int BYTE_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic                 lock,
  input  logic                 bit_stb,
  input  logic                 bit_val,
  input  logic                 both_hi,
  input  logic                 gap_lvl,
  output logic                 done,
  output logic [$clog2(WORD_BITS/BYTE_BITS)-1:0] done_idx,
  output logic [WORD_BITS-1:0] word,
  output logic                 seq_pulse
);
  localparam int CNT_W  = $clog2(WORD_BITS + 1);
  localparam int POS_W  = $clog2(WORD_BITS);
  localparam int BSEL_W = $clog2(BYTE_BITS);

  logic             armed;
  logic [CNT_W-1:0] cnt;
  logic [POS_W-1:0] pos;

  assign pos = cnt[POS_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) word <= '0;
    else if (en && !lock && armed && bit_stb && cnt != CNT_W'(WORD_BITS))
      word[pos] <= bit_val;
  end

  always_ff @(posedge clk) begin
    if (rst || !en || lock) begin
      armed     <= 1'b0;
      cnt       <= '0;
      done      <= 1'b0;
      done_idx  <= '0;
      seq_pulse <= 1'b0;
    end else begin
      done      <= 1'b0;
      seq_pulse <= 1'b0;
      if (gap_lvl) begin
        if (armed && cnt != '0 && cnt < CNT_W'(WORD_BITS)) seq_pulse <= 1'b1;
        armed <= 1'b1;
        cnt   <= '0;
      end else if (armed && both_hi) begin
        seq_pulse <= 1'b1;
        armed     <= 1'b0;
        cnt       <= '0;
      end else if (armed && bit_stb) begin
        if (cnt == CNT_W'(WORD_BITS)) begin
          seq_pulse <= 1'b1;
          armed     <= 1'b0;
          cnt       <= '0;
        end else begin
          cnt <= cnt + 1'b1;
          if (&pos[BSEL_W-1:0]) begin
            done     <= 1'b1;
            done_idx <= pos[POS_W-1:BSEL_W];
          end
        end
      end
    end
  end
endmodule

// File: rtl/a429_rx_deliver.sv
module a429_rx_deliver #(
  parameter int WORD_BITS = 32,
  parameter int BYTE_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wide,
  input  logic                 par_en,
  input  logic                 skip_wr,
  input  logic                 lbl_ok,
  input  logic                 stat_rd,
  input  logic                 data_rd,
  input  logic                 done,
  input  logic [$clog2(WORD_BITS/BYTE_BITS)-1:0] done_idx,
  input  logic [WORD_BITS-1:0] word,
  input  logic                 seq_pulse,
  output logic                 ready,
  output logic                 first,
  output logic [BYTE_BITS-1:0] data_byte,
  output logic [WORD_BITS-1:0] data_word,
  output logic                 err_par,
  output logic                 err_ovr,
  output logic                 err_seq
);
  localparam int NBYTES = WORD_BITS / BYTE_BITS;
  localparam int NB_W   = $clog2(NBYTES);
  localparam int BSEL_W = $clog2(BYTE_BITS);

  logic                 skip, drop;
  logic                 is_first, is_last, drop_now, par_bad, act;
  logic [BYTE_BITS-1:0] cur_byte;

  assign is_first = (done_idx == '0);
  assign is_last  = (done_idx == NB_W'(NBYTES - 1));
  assign drop_now = is_first ? !lbl_ok : drop;
  assign par_bad  = par_en && is_last && !(^word);
  assign act      = wide ? is_last : 1'b1;
  assign cur_byte = word[{done_idx, BSEL_W'(0)} +: BYTE_BITS];

  always_ff @(posedge clk) begin
    if (rst) begin
      ready     <= 1'b0;
      first     <= 1'b0;
      skip      <= 1'b0;
      drop      <= 1'b0;
      data_byte <= '0;
      data_word <= '0;
      err_par   <= 1'b0;
      err_ovr   <= 1'b0;
      err_seq   <= 1'b0;
    end else begin
      if (data_rd) begin
        ready <= 1'b0;
        first <= 1'b0;
      end
      if (stat_rd) begin
        err_par <= 1'b0;
        err_ovr <= 1'b0;
        err_seq <= 1'b0;
      end
      if (skip_wr)   skip    <= 1'b1;
      if (seq_pulse) err_seq <= 1'b1;
      if (done) begin
        if (is_first) drop <= !lbl_ok;
        if (is_last)  skip <= 1'b0;
        if (act && !drop_now) begin
          if (par_bad) begin
            err_par <= 1'b1;
          end else begin
            data_byte <= cur_byte;
            if (wide) data_word <= word;
            if (wide || is_first) first <= 1'b1;
            if (!skip) begin
              if (ready && !data_rd) err_ovr <= 1'b1;
              ready <= 1'b1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/a429_word_rx.sv
module a429_word_rx #(
  parameter int WORD_BITS = 32,
  parameter int BYTE_BITS = 8,
  parameter int OVS       = 4,
  parameter int GAP_CELLS = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 line_one,
  input  logic                 line_zero,
  input  logic                 ctl_enable,
  input  logic                 ctl_wide,
  input  logic                 ctl_parity_en,
  input  logic                 ctl_skip_wr,
  input  logic                 lbl_ok,
  input  logic                 stat_rd,
  input  logic                 data_rd,
  output logic                 rx_ready,
  output logic                 first_char,
  output logic [BYTE_BITS-1:0] data_byte,
  output logic [WORD_BITS-1:0] data_word,
  output logic                 err_parity,
  output logic                 err_overwrite,
  output logic                 err_seq,
  output logic                 err_any
);
  localparam int NB_W = $clog2(WORD_BITS / BYTE_BITS);

  logic                 bit_stb, bit_val, both_hi, gap_lvl;
  logic                 done, seq_pulse;
  logic [NB_W-1:0]      done_idx;
  logic [WORD_BITS-1:0] word;

  assign err_any = err_parity | err_overwrite | err_seq;

  a429_rx_sampler #(.OVS(OVS), .GAP_CELLS(GAP_CELLS)) u_smp (
    .clk(clk), .rst(rst), .en(ctl_enable),
    .line_one(line_one), .line_zero(line_zero),
    .bit_stb(bit_stb), .bit_val(bit_val), .both_hi(both_hi), .gap_lvl(gap_lvl)
  );

  a429_rx_framer #(.WORD_BITS(WORD_BITS), .BYTE_BITS(BYTE_BITS)) u_frm (
    .clk(clk), .rst(rst), .en(ctl_enable), .lock(err_any),
    .bit_stb(bit_stb), .bit_val(bit_val), .both_hi(both_hi), .gap_lvl(gap_lvl),
    .done(done), .done_idx(done_idx), .word(word), .seq_pulse(seq_pulse)
  );

  a429_rx_deliver #(.WORD_BITS(WORD_BITS), .BYTE_BITS(BYTE_BITS)) u_dlv (
    .clk(clk), .rst(rst), .wide(ctl_wide), .par_en(ctl_parity_en),
    .skip_wr(ctl_skip_wr), .lbl_ok(lbl_ok), .stat_rd(stat_rd), .data_rd(data_rd),
    .done(done), .done_idx(done_idx), .word(word), .seq_pulse(seq_pulse),
    .ready(rx_ready), .first(first_char), .data_byte(data_byte),
    .data_word(data_word), .err_par(err_parity), .err_ovr(err_overwrite),
    .err_seq(err_seq)
  );
endmodule

// File: rtl/a429_word_rx_chk.sv
module a429_word_rx_chk (
  input logic clk,
  input logic rst,
  input logic ctl_enable,
  input logic ctl_parity_en,
  input logic stat_rd,
  input logic rx_ready,
  input logic err_parity,
  input logic err_overwrite,
  input logic err_any
);
  // R11: an error holds until a status read
  p_err_holds_r11: assert property (@(posedge clk) disable iff (rst)
    (err_any && !stat_rd) |=> err_any)
    else $error("p_err_holds_r11");

  // R11: no new data is flagged while an error was pending
  p_lock_blocks_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_ready) |-> !$past(err_any))
    else $error("p_lock_blocks_r11");

  // R9: overwrite only when unread data was already present
  p_ovr_needs_ready_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(err_overwrite) |-> $past(rx_ready))
    else $error("p_ovr_needs_ready_r9");

  // R13: a receiver held disabled raises no ready
  p_disabled_quiet_r13: assert property (@(posedge clk) disable iff (rst)
    (!$past(ctl_enable) && !$past(ctl_enable, 2)) |-> !$rose(rx_ready))
    else $error("p_disabled_quiet_r13");

  // R5: parity errors only arise with checking enabled
  p_parity_gated_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(err_parity) |-> $past(ctl_parity_en))
    else $error("p_parity_gated_r5");
endmodule

bind a429_word_rx a429_word_rx_chk u_chk (
  .clk(clk), .rst(rst), .ctl_enable(ctl_enable), .ctl_parity_en(ctl_parity_en),
  .stat_rd(stat_rd), .rx_ready(rx_ready), .err_parity(err_parity),
  .err_overwrite(err_overwrite), .err_any(err_any)
);

// File: tb/tb_a429_word_rx.sv
module tb_a429_word_rx;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        line_one = 1'b0, line_zero = 1'b0;
  logic        ctl_enable = 1'b1, ctl_wide = 1'b1, ctl_parity_en = 1'b1;
  logic        ctl_skip_wr = 1'b0, lbl_ok = 1'b1, stat_rd = 1'b0, data_rd = 1'b0;
  logic        rx_ready, first_char, err_parity, err_overwrite, err_seq, err_any;
  logic [7:0]  data_byte;
  logic [31:0] data_word;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  a429_word_rx dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference: odd-parity word from 31 payload bits
  function automatic logic [31:0] mk_odd(input logic [30:0] p);
    return {~(^p), p};
  endfunction

  task automatic idle(input int n);
    line_one = 1'b0; line_zero = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // one 4-clock cell: 2 clocks pulse, 2 clocks null
  task automatic send_bit(input logic b);
    line_one = b; line_zero = ~b;
    @(negedge clk);
    data_rd = 1'b0;
    @(negedge clk);
    line_one = 1'b0; line_zero = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic send_word(input logic [31:0] w, input int nbits);
    for (int i = 0; i < nbits; i++) send_bit(w[i % 32]);
  endtask

  task automatic pulse_data_rd();
    data_rd = 1'b1; @(negedge clk); data_rd = 1'b0; @(negedge clk);
  endtask

  task automatic pulse_stat_rd();
    stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0; @(negedge clk);
  endtask

  // byte mode: check each byte as it lands, read it at once
  task automatic rx_bytes(input logic [31:0] w, input bit bad_par);
    for (int i = 0; i < 32; i++) begin
      send_bit(w[i]);
      if (i % 8 == 7) begin
        if (i == 31 && bad_par) begin
          chk(rx_ready == 1'b0, "R5 byte4 not ready on bad parity", rx_ready, 0);
          chk(err_parity == 1'b1, "R5 byte-mode parity flag", err_parity, 1);
        end else begin
          chk(rx_ready == 1'b1, "R4 byte ready", rx_ready, 1);
          chk(data_byte == w[i-7 +: 8], "R4 R1 byte value", data_byte, w[i-7 +: 8]);
          chk(first_char == (i == 7), "R4 first-character only on byte 1", first_char, (i == 7));
          data_rd = 1'b1;
        end
      end
    end
    @(negedge clk);
    data_rd = 1'b0;
  endtask

  initial begin : main
    logic [31:0] w;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    chk(rx_ready == 0 && err_any == 0 && first_char == 0, "R2 reset state", {rx_ready, err_any, first_char}, 0);

    // R2: a word with no gap in front of it after reset is ignored
    send_word(mk_odd(31'h1234_5678), 32);
    idle(16);
    chk(rx_ready == 1'b0, "R2 word before gap ignored", rx_ready, 0);
    chk(err_any == 1'b0, "R2 no flag for ignored bits", err_any, 0);

    // R3 / R1: exact latency of the last bit
    w = mk_odd(31'h0A5C_3E01);
    send_word(w, 31);
    line_one = w[31]; line_zero = ~w[31];
    @(negedge clk);
    @(negedge clk);
    line_one = 1'b0; line_zero = 1'b0;
    @(negedge clk);
    chk(rx_ready == 1'b0, "R3 ready not yet after 2 edges", rx_ready, 0);
    @(negedge clk);
    chk(rx_ready == 1'b1, "R3 ready on 3rd edge", rx_ready, 1);
    chk(first_char == 1'b1, "R3 word-valid", first_char, 1);
    chk(data_word == w, "R1 R3 word value and order", data_word, w);
    pulse_data_rd();
    chk(rx_ready == 0 && first_char == 0, "R14 read clears ready", {rx_ready, first_char}, 0);

    // R9: two words unread
    idle(16); send_word(mk_odd(31'h0000_1111), 32);
    idle(16); w = mk_odd(31'h7777_0000); send_word(w, 32);
    idle(4);
    chk(err_overwrite == 1'b1, "R9 overwrite flag", err_overwrite, 1);
    chk(rx_ready == 1'b1, "R9 ready kept", rx_ready, 1);
    chk(data_word == w, "R9 newer data kept", data_word, w);
    pulse_stat_rd();
    chk(err_any == 1'b0, "R11 status read clears errors", err_any, 0);
    pulse_data_rd();

    // R5: even parity word
    idle(16); send_word({1'b0, 31'h0000_0003}, 32);
    idle(4);
    chk(err_parity == 1'b1, "R5 parity error", err_parity, 1);
    chk(rx_ready == 1'b0, "R5 no ready on parity error", rx_ready, 0);
    // R11: locked receiver ignores a good word
    idle(16); send_word(mk_odd(31'h0101_0101), 32);
    idle(4);
    chk(rx_ready == 1'b0, "R11 locked while error pending", rx_ready, 0);
    pulse_stat_rd();
    idle(16); w = mk_odd(31'h0202_0202); send_word(w, 32);
    idle(4);
    chk(rx_ready == 1'b1 && data_word == w, "R11 receives after clear", data_word, w);
    pulse_data_rd();

    // R5: parity disabled, bit 31 is data
    ctl_parity_en = 1'b0;
    idle(16); w = {1'b1, 31'h0000_0001}; send_word(w, 32);
    idle(4);
    chk(err_parity == 1'b0 && rx_ready == 1'b1, "R5 no check when disabled", {err_parity, rx_ready}, 1);
    chk(data_word == w, "R5 bit 31 kept as data", data_word, w);
    pulse_data_rd();
    ctl_parity_en = 1'b1;

    // R6: both lines high
    idle(16); send_word(32'h5, 4);
    line_one = 1'b1; line_zero = 1'b1; @(negedge clk); @(negedge clk);
    idle(16);
    chk(err_seq == 1'b1, "R6 both-high sequence error", err_seq, 1);
    pulse_stat_rd();

    // R7: short word
    idle(16); send_word(32'hFFFF_FFFF, 20);
    idle(16);
    chk(err_seq == 1'b1, "R7 short word sequence error", err_seq, 1);
    chk(rx_ready == 1'b0, "R7 no ready for short word", rx_ready, 0);
    pulse_stat_rd();

    // R8: 33 bits
    idle(16); w = mk_odd(31'h3C3C_3C3C); send_word(w, 33);
    idle(16);
    chk(err_seq == 1'b1, "R8 long word sequence error", err_seq, 1);
    chk(rx_ready == 1'b1 && data_word == w, "R8 first 32 bits delivered", data_word, w);
    pulse_stat_rd();
    pulse_data_rd();

    // R10: one-word ready suppression
    ctl_skip_wr = 1'b1; @(negedge clk); ctl_skip_wr = 1'b0;
    idle(16); w = mk_odd(31'h4444_5555); send_word(w, 32);
    idle(4);
    chk(rx_ready == 1'b0, "R10 ready suppressed", rx_ready, 0);
    chk(first_char == 1'b1 && data_word == w, "R10 word-valid still set", data_word, w);
    pulse_data_rd();
    idle(16); send_word(mk_odd(31'h0000_0F0F), 32);
    idle(4);
    chk(rx_ready == 1'b1, "R10 suppression self-clears", rx_ready, 1);
    pulse_data_rd();

    // R12: label filter rejects
    lbl_ok = 1'b0;
    idle(16); send_word(mk_odd(31'h6666_0066), 32);
    idle(4);
    chk({rx_ready, first_char, err_any} == 3'b000, "R12 rejected label leaves no trace",
        {rx_ready, first_char, err_any}, 0);
    lbl_ok = 1'b1;

    // R13: disabled receiver
    ctl_enable = 1'b0;
    idle(16); send_word(mk_odd(31'h0123_4567), 32);
    idle(4);
    chk(rx_ready == 1'b0 && err_any == 1'b0, "R13 disabled ignores lines", rx_ready, 0);
    ctl_enable = 1'b1;

    // R4: byte mode, clean word then bad parity word
    ctl_wide = 1'b0;
    idle(16); rx_bytes(mk_odd(31'h1A2B_3C4D), 1'b0);
    idle(16); rx_bytes({1'b1, 31'h0000_0001}, 1'b1);
    pulse_stat_rd();

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule